// File: doc/BRIEF.md
# Dual DAC Sample-Pair Source Router

This block feeds two digital-to-analog converter channels whose conversion clock runs at twice the fabric clock. On every fabric clock it hands a double-data-rate output stage one pair of samples per channel: an even sample for the first half of the fabric period and an odd sample for the second half. Each channel picks its own source: a single-rate filter output, a sample pair from a direct digital synthesis core, a circular waveform memory, or silence.

The waveform memory holds one full period of an arbitrary waveform. It is read two entries per fabric clock, so it plays at the full converter rate. It loops without ever stopping. Because the loop is fixed at the memory depth in converter samples, any periodic waveform it produces sits on a frequency grid of f_conv/DEPTH. A simple register-bus write port can load or change entries at any time, including while playback is running. A global converter enable forces both channels to zero.

Top module: `dual_dac_feeder`

## Requirements
- R1: While `rstN` is low, all four sample outputs read zero, and the playback pointer returns to entry 0.
- R2: Each channel decodes its own 2-bit select independently: 0 = silent, 1 = filter, 2 = synthesizer pair, 3 = waveform memory. The two channels may use different sources in the same cycle.
- R3: A channel with select 0 outputs zero in both slots.
- R4: A channel with select 1 outputs the single-rate `iirSample` in both the even slot and the odd slot.
- R5: A channel with select 2 outputs `ddsEven` in the even slot and `ddsOdd` in the odd slot.
- R6: A channel with select 3 outputs waveform memory entries 2k and 2k+1 in the even and odd slots. k advances by one every fabric cycle and wraps from entry pair DEPTH-2/DEPTH-1 back to 0, with no pause.
- R7: When `wrEn` is high at a clock edge, `wrData` is stored at `wrAddr`. This works during reset and during playback. A stored value appears when playback next fetches that entry; a fetch on the same edge as the write still returns the old value.
- R8: Outputs are registered. Select, enable, filter and synthesizer inputs sampled at one edge appear after that edge, so both samples of a pair always come from the same source.
- R9: While `dacEnable` is low at an edge, both channels output zero in both slots, whatever their selects.
- R10: The first memory fetch (entries 0 and 1) happens on the first edge with `rstN` high. Its data is shown by a channel with select 3 after the second such edge. Each later edge shows the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (half the converter rate) |
| rstN | input | 1 | Synchronous active-low reset |
| dacEnable | input | 1 | Converter enable; low silences both channels |
| selCh0 | input | 2 | Source select, channel 0 |
| selCh1 | input | 2 | Source select, channel 1 |
| iirSample | input | SAMPLE_W | Single-rate filter sample |
| ddsEven | input | SAMPLE_W | Synthesizer sample, first half-period |
| ddsOdd | input | SAMPLE_W | Synthesizer sample, second half-period |
| wrEn | input | 1 | Waveform memory write strobe |
| wrAddr | input | ADDR_W | Waveform memory write address |
| wrData | input | SAMPLE_W | Waveform memory write data |
| ch0Even | output | SAMPLE_W | Channel 0 even-slot sample |
| ch0Odd | output | SAMPLE_W | Channel 0 odd-slot sample |
| ch1Even | output | SAMPLE_W | Channel 1 even-slot sample |
| ch1Odd | output | SAMPLE_W | Channel 1 odd-slot sample |

## Verification
The bench builds the block with DEPTH = 64 (ADDR_W = 6) and the default 14-bit samples. With this depth the playback pointer wraps every 32 fabric cycles, so thousands of cycles of random selects and writes cross the wrap boundary many times. Writes often hit the very entry being fetched, which tests the old-data-on-same-edge rule. Filling the whole memory during reset also takes only 64 cycles, so every fetch returns a known value from the first edge on.

// File: rtl/dac_feed_pkg.sv
package dac_feed_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_IIR = 2'd1,
    SRC_DDS = 2'd2,
    SRC_ARB = 2'd3
  } srcSel_e;

  // One-hot (or all-zero) source pick for one channel
  typedef struct packed {
    logic pickIir;
    logic pickDds;
    logic pickArb;
  } chanPick_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    chanPick_t [NUM_CH-1:0] pick;
  } feedStrobes_t;

endpackage

// File: rtl/dac_feed_ctrl.sv
module dac_feed_ctrl
  import dac_feed_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dacEnable,
  input  logic [NUM_CH-1:0][1:0]       selIn,
  output feedStrobes_t                 strobes,
  output logic [ADDR_W-1:0]            rdAddr
);

  localparam logic [ADDR_W-1:0] LAST_PAIR = ADDR_W'(DEPTH - 2);

  // Select decode, gated by the converter enable
  always_comb begin
    strobes = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.pick[ch].pickIir = dacEnable && (srcSel_e'(selIn[ch]) == SRC_IIR);
      strobes.pick[ch].pickDds = dacEnable && (srcSel_e'(selIn[ch]) == SRC_DDS);
      strobes.pick[ch].pickArb = dacEnable && (srcSel_e'(selIn[ch]) == SRC_ARB);
    end
  end

  // Playback pointer: even entry of the pair to fetch, loops forever
  always_ff @(posedge clk) begin
    if (!rstN)                    rdAddr <= '0;
    else if (rdAddr == LAST_PAIR) rdAddr <= '0;
    else                          rdAddr <= rdAddr + ADDR_W'(2);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobes.pick[g])) else $error("more than one source picked"); // R2
  end

endmodule

// File: rtl/dac_feed_data.sv
module dac_feed_data
  import dac_feed_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 2048,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  feedStrobes_t                        strobes,
  input  logic [ADDR_W-1:0]                   rdAddr,
  input  logic [SAMPLE_W-1:0]                 iirSample,
  input  logic [SAMPLE_W-1:0]                 ddsEven,
  input  logic [SAMPLE_W-1:0]                 ddsOdd,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [SAMPLE_W-1:0]                 wrData,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]     outEven,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]     outOdd
);

  logic [SAMPLE_W-1:0] waveMem [DEPTH];
  logic [SAMPLE_W-1:0] arbEven;
  logic [SAMPLE_W-1:0] arbOdd;

  // Register-bus write port, open during reset and playback
  always_ff @(posedge clk) begin
    if (wrEn) waveMem[wrAddr] <= wrData;
  end

  // Synchronous pair fetch; a same-edge write is not seen yet
  always_ff @(posedge clk) begin
    if (!rstN) begin
      arbEven <= '0;
      arbOdd  <= '0;
    end else begin
      arbEven <= waveMem[rdAddr];
      arbOdd  <= waveMem[rdAddr + ADDR_W'(1)];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outEven[g] <= '0;
        outOdd[g]  <= '0;
      end else if (strobes.pick[g].pickIir) begin
        outEven[g] <= iirSample;
        outOdd[g]  <= iirSample;
      end else if (strobes.pick[g].pickDds) begin
        outEven[g] <= ddsEven;
        outOdd[g]  <= ddsOdd;
      end else if (strobes.pick[g].pickArb) begin
        outEven[g] <= arbEven;
        outOdd[g]  <= arbOdd;
      end else begin
        outEven[g] <= '0;
        outOdd[g]  <= '0;
      end
    end

    AST_IIR_BOTH_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.pick[g].pickIir) |-> (outEven[g] == outOdd[g]))
      else $error("filter pair differs"); // R4

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobes.pick[g]) == '0) |-> (outEven[g] == '0 && outOdd[g] == '0))
      else $error("silent channel not zero"); // R3

    AST_ARB_PAIR: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.pick[g].pickArb) |->
        (outEven[g] == $past(arbEven) && outOdd[g] == $past(arbOdd)))
      else $error("memory pair mismatch"); // R6
  end

endmodule

// File: rtl/dual_dac_feeder.sv
module dual_dac_feeder
  import dac_feed_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 2048,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dacEnable,
  input  logic [1:0]          selCh0,
  input  logic [1:0]          selCh1,
  input  logic [SAMPLE_W-1:0] iirSample,
  input  logic [SAMPLE_W-1:0] ddsEven,
  input  logic [SAMPLE_W-1:0] ddsOdd,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [SAMPLE_W-1:0] wrData,
  output logic [SAMPLE_W-1:0] ch0Even,
  output logic [SAMPLE_W-1:0] ch0Odd,
  output logic [SAMPLE_W-1:0] ch1Even,
  output logic [SAMPLE_W-1:0] ch1Odd
);

  feedStrobes_t                      strobes;
  logic [ADDR_W-1:0]                 rdAddr;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]   outEven;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]   outOdd;

  dac_feed_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .dacEnable (dacEnable),
    .selIn     ({selCh1, selCh0}),
    .strobes   (strobes),
    .rdAddr    (rdAddr)
  );

  dac_feed_data #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdAddr    (rdAddr),
    .iirSample (iirSample),
    .ddsEven   (ddsEven),
    .ddsOdd    (ddsOdd),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .outEven   (outEven),
    .outOdd    (outOdd)
  );

  assign ch0Even = outEven[0];
  assign ch0Odd  = outOdd[0];
  assign ch1Even = outEven[1];
  assign ch1Odd  = outOdd[1];

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dacEnable) |->
      (ch0Even == '0 && ch0Odd == '0 && ch1Even == '0 && ch1Odd == '0))
    else $error("output while converter disabled"); // R9

endmodule

// File: tb/tb_dual_dac_feeder.sv
module tb_dual_dac_feeder;

  localparam int SW     = 14;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dacEnable = 1'b0;
  logic [1:0] sel [2];
  logic [SW-1:0] iirSample = '0, ddsEven = '0, ddsOdd = '0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [SW-1:0] wrData = '0;
  logic [SW-1:0] ch0Even, ch0Odd, ch1Even, ch1Odd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_dac_feeder #(.SAMPLE_W(SW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .dacEnable(dacEnable),
    .selCh0(sel[0]), .selCh1(sel[1]),
    .iirSample(iirSample), .ddsEven(ddsEven), .ddsOdd(ddsOdd),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ch0Even(ch0Even), .ch0Odd(ch0Odd), .ch1Even(ch1Even), .ch1Odd(ch1Odd)
  );

  // ---------------- reference model from the requirements ----------------
  logic [SW-1:0] shadow [DEPTH];
  int            mPtr;
  logic [SW-1:0] mArbE, mArbO;
  logic [SW-1:0] mE [2];
  logic [SW-1:0] mO [2];
  string         mTag [2];

  // Expected {even, odd} for one channel (R2..R6, R9)
  function automatic logic [2*SW-1:0] expPair(logic en, logic [1:0] s,
      logic [SW-1:0] iir, logic [SW-1:0] de, logic [SW-1:0] dOd,
      logic [SW-1:0] ae, logic [SW-1:0] ao);
    if (!en) return '0;
    case (s)
      2'd1:    return {iir, iir};
      2'd2:    return {de, dOd};
      2'd3:    return {ae, ao};
      default: return '0;
    endcase
  endfunction

  function automatic string tagOf(logic en, logic [1:0] s);
    if (!en) return "R9";
    case (s)
      2'd1:    return "R4";
      2'd2:    return "R5";
      2'd3:    return "R6";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr  = 0;
      mArbE = '0;
      mArbO = '0;
      for (int c = 0; c < 2; c++) begin
        mE[c] = '0; mO[c] = '0; mTag[c] = "R1";
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [2*SW-1:0] p;
        p = expPair(dacEnable, sel[c], iirSample, ddsEven, ddsOdd, mArbE, mArbO);
        mE[c] = p[2*SW-1:SW];
        mO[c] = p[SW-1:0];
        mTag[c] = tagOf(dacEnable, sel[c]);
      end
      // R10: fetch happens now, is shown one edge later
      mArbE = shadow[mPtr];
      mArbO = shadow[mPtr + 1];
      mPtr  = (mPtr + 2) % DEPTH;
    end
    // R7: write lands after the same-edge fetch
    if (wrEn) shadow[wrAddr] = wrData;
  end

  // ---------------- checking ----------------
  task automatic cmp(string phase, string tag, string what,
                     logic [SW-1:0] got, logic [SW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s: got %h expected %h", tag, phase, what, got, exp);
    end
  endtask

  task automatic stepCheck(string phase);
    @(negedge clk);
    cmp(phase, mTag[0], "ch0 even", ch0Even, mE[0]);
    cmp(phase, mTag[0], "ch0 odd",  ch0Odd,  mO[0]);
    cmp(phase, mTag[1], "ch1 even", ch1Even, mE[1]);
    cmp(phase, mTag[1], "ch1 odd",  ch1Odd,  mO[1]);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h0dac_5eed));
    sel[0] = 2'd0;
    sel[1] = 2'd0;
    @(negedge clk);
    // R1, R7: fill the memory while held in reset; outputs must stay zero
    for (int i = 0; i < DEPTH; i++) begin
      wrEn   = 1'b1;
      wrAddr = ADDR_W'(i);
      wrData = SW'($urandom);
      sel[0] = 2'($urandom);
      sel[1] = 2'($urandom);
      dacEnable = 1'b1;
      stepCheck("R1 reset hold");
    end
    wrEn = 1'b0;
    rstN = 1'b1;

    // R2, R6, R10: channel 0 plays memory, channel 1 follows the filter,
    // across several wraps of the pointer
    sel[0] = 2'd3;
    sel[1] = 2'd1;
    for (int i = 0; i < 3 * DEPTH; i++) begin
      iirSample = SW'($urandom);
      ddsEven   = SW'($urandom);
      ddsOdd    = SW'($urandom);
      stepCheck("R2 R6 R10 mixed sources and wrap");
    end

    // R9: enable low with every select combination
    for (int i = 0; i < 16; i++) begin
      dacEnable = 1'b0;
      sel[0] = 2'(i);
      sel[1] = 2'(i >> 2);
      iirSample = SW'($urandom);
      ddsEven   = SW'($urandom);
      ddsOdd    = SW'($urandom);
      stepCheck("R9 disabled");
    end

    // R7: write the entry the pointer is about to fetch, and its neighbour
    dacEnable = 1'b1;
    sel[0] = 2'd3;
    sel[1] = 2'd3;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      wrEn   = 1'b1;
      wrAddr = ADDR_W'((mPtr + (i % 3)) % DEPTH);
      wrData = SW'($urandom);
      stepCheck("R7 write during playback");
    end
    wrEn = 1'b0;

    // R3..R9 and R8: random selects, data, enable and writes
    for (int i = 0; i < 4000; i++) begin
      dacEnable = ($urandom % 8) != 0;
      sel[0]    = 2'($urandom);
      sel[1]    = 2'($urandom);
      iirSample = SW'($urandom);
      ddsEven   = SW'($urandom);
      ddsOdd    = SW'($urandom);
      wrEn      = ($urandom % 4) == 0;
      wrAddr    = ADDR_W'($urandom);
      wrData    = SW'($urandom);
      stepCheck("R8 random traffic");
    end
    wrEn = 1'b0;

    // R1: reset again mid-run, pointer and outputs return to start
    rstN = 1'b0;
    stepCheck("R1 re-reset");
    stepCheck("R1 re-reset");
    rstN = 1'b1;
    sel[0] = 2'd3;
    sel[1] = 2'd2;
    for (int i = 0; i < 8; i++) begin
      ddsEven = SW'($urandom);
      ddsOdd  = SW'($urandom);
      stepCheck("R10 restart from entry 0");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule